// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level tree of translation tables kept in ordinary memory. A requester presents the virtual address, the base of the root table and the kind of access: read or write, user or supervisor. The walker then fetches one 4-byte entry per level through a simple read request/response port. It finishes with either a physical address or a fault with a cause code.

The address is cut into a 10-bit root index in bits 31:22, a 10-bit inner index in bits 21:12 and a 12-bit page offset in bits 11:0. With 1024 four-byte entries, every table fills exactly one 4 KiB page. A root entry that is valid names the frame holding the inner table. A valid inner entry names the data frame. The walk stops at the first entry that is invalid or that forbids the access, and makes no further memory reads. The walker handles one request at a time.

Top module: `page_walker`

## Requirements
- R1: After reset, reqReady is 1 and done, resFault, resCause and memReqValid are all 0.
- R2: The first read goes to the root table frame (reqRoot bits 31:12, with reqRoot bits 11:0 ignored) plus four times the virtual address bits 31:22. Every read address is 4-byte aligned.
- R3: The second read goes to the frame in bits 31:12 of the root entry plus four times the virtual address bits 21:12.
- R4: memReqValid stays high with memReqAddr unchanged until a cycle in which memReqReady is high. The walker waits for memRspValid before it uses a response.
- R5: A walk in which both entries allow the access makes exactly two reads and ends with resFault=0, resCause=0 and resPaddr equal to the inner entry's bits 31:12 followed by the virtual address bits 11:0. For example, virtual address 0x00801234 with inner frame 0x000AB gives 0x000AB234.
- R6: A root entry with bit 0 (valid) clear ends the walk after one read, with resFault=1, resCause=3'b001 and resPaddr=0.
- R7: An inner entry with bit 0 clear ends the walk with resFault=1, resCause=3'b010 and resPaddr=0.
- R8: A valid entry at either level causes a permission fault when the access is a write and the entry's bit 1 (writable) is clear, or when the access is a user access and the entry's bit 2 (user) is clear. The fault code is 3'b101 at the root level and 3'b110 at the inner level. A root-level permission fault stops after one read. Supervisor reads are never refused. An invalid entry reports the not-present code even if its permission bits would also refuse the access.
- R9: Entry bits 5 (accessed) and 6 (dirty) have no effect on the addresses read or on the result.
- R10: reqReady is high only while idle, so a request presented during a walk is ignored. done is a one-cycle pulse, and reqReady returns in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and accepting a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqRoot | input | 32 | Root table base (page aligned, low 12 bits ignored) |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| reqUser | input | 1 | 1 = user-mode access, 0 = supervisor |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data is present |
| memRspData | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle pulse: result or fault is valid |
| resPaddr | output | 32 | Translated physical address (0 on fault) |
| resFault | output | 1 | Walk ended in a fault |
| resCause | output | 3 | Fault code: bit 2 = permission, bits 1:0 = level (1 root, 2 inner) |

## Verification
The checker watches the handshake rules on every cycle. It confirms that a pending read holds its address until accepted, that read addresses are aligned, and that reqReady is never high together with an outstanding read. It also confirms that done lasts one cycle and is followed by reqReady, and that the fault flag and the cause code agree. The bench scenarios cover what depends on entry contents. These include the two entry addresses, the physical address, and whether the walk stops after one read or goes on to two. They also include how the valid, writable and user bits combine with each access type, and the claim that the accessed and dirty bits change nothing. The bench sweeps every combination of the three flag bits at both levels against all four access types, with varied memory latency.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    IDLE    = 3'd0,
    READ_L1 = 3'd1,
    WAIT_L1 = 3'd2,
    READ_L2 = 3'd3,
    WAIT_L2 = 3'd4,
    DONE    = 3'd5
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture the incoming request
    logic selL2;     // address the inner table instead of the root table
    logic takeL1;    // consume a root-level response
    logic takeL2;    // consume an inner-level response
  } walkStrobe_t;

  localparam int unsigned ENTRY_VALID_BIT = 0;
  localparam int unsigned ENTRY_WRITE_BIT = 1;
  localparam int unsigned ENTRY_USER_BIT  = 2;

  localparam int unsigned CAUSE_W = 3;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        stopNow,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        done,
  output walkStrobe_t strb
);

  walkState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    done        = 1'b0;
    strb        = '0;
    unique case (stateQ)
      IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          stateD        = READ_L1;
        end
      end
      READ_L1: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = WAIT_L1;
      end
      WAIT_L1: begin
        if (memRspValid) begin
          strb.takeL1 = 1'b1;
          stateD      = stopNow ? DONE : READ_L2;
        end
      end
      READ_L2: begin
        strb.selL2  = 1'b1;
        memReqValid = 1'b1;
        if (memReqReady) stateD = WAIT_L2;
      end
      WAIT_L2: begin
        strb.selL2 = 1'b1;
        if (memRspValid) begin
          strb.takeL2 = 1'b1;
          stateD      = DONE;
        end
      end
      DONE: begin
        done   = 1'b1;
        stateD = IDLE;
      end
      default: stateD = IDLE;
    endcase
  end

endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strb,
  input  logic [ADDR_W-1:0]   reqVaddr,
  input  logic [ADDR_W-1:0]   reqRoot,
  input  logic                reqWrite,
  input  logic                reqUser,
  input  logic [ADDR_W-1:0]   memRspData,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic                stopNow,
  output logic [ADDR_W-1:0]   resPaddr,
  output logic                resFault,
  output logic [CAUSE_W-1:0]  resCause
);

  localparam int unsigned FRAME_W     = ADDR_W - OFF_W;
  localparam int unsigned ENTRY_BYTES = ADDR_W / 8;
  localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic [ADDR_W-1:0]  vaddrQ;
  logic [FRAME_W-1:0] rootFrameQ;
  logic [FRAME_W-1:0] innerFrameQ;
  logic               writeQ;
  logic               userQ;
  logic [ADDR_W-1:0]  paddrQ;
  logic               faultQ;
  logic [CAUSE_W-1:0] causeQ;

  logic [IDX_W-1:0]   idxTop;
  logic [IDX_W-1:0]   idxLow;
  logic [IDX_W-1:0]   curIdx;
  logic [FRAME_W-1:0] curFrame;
  logic [ADDR_W-1:0]  frameAddr;
  logic [ADDR_W-1:0]  idxAddr;
  logic [FRAME_W-1:0] rspFrame;
  logic               entryValid;
  logic               permBad;
  logic [1:0]         stopLevel;
  logic [CAUSE_W-1:0] stopCause;

  // address generation
  assign idxTop    = vaddrQ[ADDR_W-1 -: IDX_W];
  assign idxLow    = vaddrQ[OFF_W +: IDX_W];
  assign curIdx    = strb.selL2 ? idxLow : idxTop;
  assign curFrame  = strb.selL2 ? innerFrameQ : rootFrameQ;
  assign frameAddr = {curFrame, {OFF_W{1'b0}}};
  assign idxAddr   = ADDR_W'(curIdx) << ENTRY_SHIFT;
  assign memReqAddr = frameAddr + idxAddr;

  // entry checks
  assign rspFrame   = memRspData[ADDR_W-1 -: FRAME_W];
  assign entryValid = memRspData[ENTRY_VALID_BIT];
  assign permBad    = (writeQ & ~memRspData[ENTRY_WRITE_BIT]) |
                      (userQ  & ~memRspData[ENTRY_USER_BIT]);
  assign stopNow    = ~entryValid | permBad;
  assign stopLevel  = strb.takeL2 ? 2'd2 : 2'd1;
  // a stop on a valid entry can only be a permission refusal
  assign stopCause  = {entryValid, stopLevel};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ      <= '0;
      rootFrameQ  <= '0;
      innerFrameQ <= '0;
      writeQ      <= 1'b0;
      userQ       <= 1'b0;
      paddrQ      <= '0;
      faultQ      <= 1'b0;
      causeQ      <= '0;
    end else begin
      if (strb.latchReq) begin
        vaddrQ     <= reqVaddr;
        rootFrameQ <= reqRoot[ADDR_W-1 -: FRAME_W];
        writeQ     <= reqWrite;
        userQ      <= reqUser;
        paddrQ     <= '0;
        faultQ     <= 1'b0;
        causeQ     <= '0;
      end
      if (strb.takeL1) begin
        if (stopNow) begin
          faultQ <= 1'b1;
          causeQ <= stopCause;
        end else begin
          innerFrameQ <= rspFrame;
        end
      end
      if (strb.takeL2) begin
        if (stopNow) begin
          faultQ <= 1'b1;
          causeQ <= stopCause;
        end else begin
          paddrQ <= {rspFrame, vaddrQ[OFF_W-1:0]};
        end
      end
    end
  end

  assign resPaddr = paddrQ;
  assign resFault = faultQ;
  assign resCause = causeQ;

  logic unusedBits;
  assign unusedBits = ^{reqRoot[OFF_W-1:0], memRspData[OFF_W-1:ENTRY_USER_BIT+1]};

endmodule

// File: rtl/page_walker.sv
module page_walker
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [ADDR_W-1:0] reqRoot,
  input  logic              reqWrite,
  input  logic              reqUser,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              done,
  output logic [ADDR_W-1:0] resPaddr,
  output logic              resFault,
  output logic [2:0]        resCause
);

  walkStrobe_t strb;
  logic        stopNow;

  pgwalk_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .stopNow     (stopNow),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .done        (done),
    .strb        (strb)
  );

  pgwalk_dpath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqVaddr   (reqVaddr),
    .reqRoot    (reqRoot),
    .reqWrite   (reqWrite),
    .reqUser    (reqUser),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .stopNow    (stopNow),
    .resPaddr   (resPaddr),
    .resFault   (resFault),
    .resCause   (resCause)
  );

endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              done,
  input logic              resFault,
  input logic [2:0]        resCause
);

  assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[1:0] == 2'b00);

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && reqReady);

  assert_fault_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && resFault |-> resCause[1:0] != 2'b00 && resCause[1:0] != 2'b11);

  assert_clean_result_R5: assert property (@(posedge clk) disable iff (!rstN)
    done && !resFault |-> resCause == 3'b000);

endmodule

bind page_walker page_walker_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .done        (done),
  .resFault    (resFault),
  .resCause    (resCause)
);

// File: tb/page_walker_tb_top.sv
module page_walker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [31:0] reqRoot = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        done;
  logic [31:0] resPaddr;
  logic        resFault;
  logic [2:0]  resCause;

  int total = 0;
  int bad = 0;

  logic [31:0] l1Entry, l2Entry;
  logic [31:0] rdAddr [4];
  int          rdCnt = 0;
  int          memDelay = 0;

  always #5 clk = ~clk;

  page_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqRoot(reqRoot), .reqWrite(reqWrite), .reqUser(reqUser),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .done(done),
    .resPaddr(resPaddr), .resFault(resFault), .resCause(resCause)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkEntry(input logic [19:0] fr, input logic [2:0] fl, input logic [1:0] ad);
    return {fr, 5'b0, ad, 2'b0, fl};
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        logic [31:0] firstAddr;
        firstAddr = memReqAddr;
        repeat (memDelay) @(negedge clk);
        chk(memReqValid && memReqAddr == firstAddr, "R4 request held", memReqAddr, firstAddr);
        if (rdCnt < 4) rdAddr[rdCnt] = memReqAddr;
        rdCnt++;
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        repeat (memDelay) @(negedge clk);
        memRspData  = (rdCnt == 1) ? l1Entry : l2Entry;
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
        memRspData  = 32'hDEAD_BEEF;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] root, input bit wr, input bit us,
                      input logic [31:0] e1, input logic [31:0] e2, input int dly);
    int n;
    int expReads;
    logic [2:0] expCause;
    logic [31:0] expPaddr;
    string tag;
    bit ok;
    l1Entry  = e1;
    l2Entry  = e2;
    rdCnt    = 0;
    memDelay = dly;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqVaddr = va; reqRoot = root; reqWrite = wr; reqUser = us;
    @(negedge clk);
    // busy: this request must be ignored
    reqVaddr = ~va; reqRoot = ~root; reqWrite = ~wr; reqUser = ~us;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n < 100, "R10 walk completes", 32'(n), 32'd0);

    expPaddr = '0;
    if (!e1[0]) begin
      expReads = 1; expCause = 3'b001; tag = "R6";
    end else if ((wr && !e1[1]) || (us && !e1[2])) begin
      expReads = 1; expCause = 3'b101; tag = "R8";
    end else if (!e2[0]) begin
      expReads = 2; expCause = 3'b010; tag = "R7";
    end else if ((wr && !e2[1]) || (us && !e2[2])) begin
      expReads = 2; expCause = 3'b110; tag = "R8";
    end else begin
      expReads = 2; expCause = 3'b000; expPaddr = {e2[31:12], va[11:0]};
      tag = ((e1[6:5] != 0) || (e2[6:5] != 0)) ? "R9" : "R5";
    end

    chk(rdCnt == expReads, {tag, " read count"}, 32'(rdCnt), 32'(expReads));
    chk(rdAddr[0] == {root[31:12], va[31:22], 2'b00}, "R2 root entry address",
        rdAddr[0], {root[31:12], va[31:22], 2'b00});
    if (expReads == 2 && rdCnt >= 2)
      chk(rdAddr[1] == {e1[31:12], va[21:12], 2'b00}, "R3 inner entry address",
          rdAddr[1], {e1[31:12], va[21:12], 2'b00});
    ok = (resFault == (expCause != 0)) && (resCause == expCause);
    chk(ok, {tag, " fault/cause"}, {28'(resCause), 3'b0, resFault}, {28'(expCause), 3'b0, expCause != 0});
    chk(resPaddr == expPaddr, {tag, " physical address"}, resPaddr, expPaddr);
    @(negedge clk);
    chk(!done && reqReady, "R10 done pulse then ready", {30'b0, done, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 reset ready", 32'(reqReady), 32'd1);
    chk({done, resFault, resCause, memReqValid} == 6'b0, "R1 reset outputs",
        {26'b0, done, resFault, resCause, memReqValid}, 32'd0);

    // worked example: 0x00801234 -> frame 0xAB
    walk(32'h0080_1234, 32'h0001_0000, 1'b0, 1'b0,
         mkEntry(20'h00022, 3'b111, 2'b00), mkEntry(20'h000AB, 3'b111, 2'b00), 0);
    chk(rdAddr[0] == 32'h0001_0008, "R2 example root address", rdAddr[0], 32'h0001_0008);
    chk(rdAddr[1] == 32'h0002_2004, "R3 example inner address", rdAddr[1], 32'h0002_2004);
    chk(resPaddr == 32'h000A_B234, "R5 example physical address", resPaddr, 32'h000A_B234);

    // sweep all flag combinations against all access types
    for (int a = 0; a < 4; a++) begin
      for (int f1 = 0; f1 < 8; f1++) begin
        for (int f2 = 0; f2 < 8; f2++) begin
          logic [31:0] va, root, e1, e2;
          va   = {10'(f1 * 113 + a * 7 + 3), 10'(f2 * 59 + a), 12'(f1 * 397 + f2 * 13)};
          root = {20'(32'h12345 + f1 * 4 + a), 12'hABC};
          e1   = mkEntry(20'(32'h40000 + f2 * 17 + a * 3), 3'(f1), 2'((f1 + f2) % 4));
          e2   = mkEntry(20'(f1 * 771 + f2 * 5 + a), 3'(f2), 2'((f1 + 2 * f2 + a) % 4));
          walk(va, root, a[0], a[1], e1, e2, (f1 + f2 + a) % 3);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule